// File: doc/BRIEF.md
# Centred Seven-Segment Space-Vector Period Sequencer

This block plays out one sampling period of space-vector modulation for a three-level neutral-point-clamped inverter. At a period strobe it captures two active dwell times (in clock ticks) and three 12-bit transistor words: one for the zero vector and one for each of the two neighbouring active vectors. It then works out the zero-vector time. Over the next period it steps through a seven-segment pattern that is symmetric about the centre, so each period opens and closes on the zero vector.

The order of the two active vectors is swapped on every period. This keeps successive periods mirror images of each other. The transistor word passes through a per-transistor turn-on delay before it reaches the output. A transistor is switched off at once, but it is switched on only after its request has stood for the dead time. This gives the complementary devices time to stop conducting. The block sits between a vector-angle stage that supplies dwell times and words, and the isolated gate drivers.

Top module: `svm_segment_seq`

## Requirements
- R1: During and after reset the gate output is all zero. The first period after reset uses the normal order, in which the vector on `gateA` follows the opening zero segment. Output bit i drives transistor i+1, and a 1 means the transistor is on.
- R2: A strobe sampled at clock edge E0 starts a period of exactly PERIOD_TICKS ticks. Tick k is the window between edge Ek and edge Ek+1. The word requested for tick k reaches `gateOut` at edge Ek+1, subject to R7 and R8.
- R3: In the normal order the segments are, in turn: zero for q ticks, A for a ticks, B for b ticks, zero for c ticks, B for b ticks, A for a ticks, zero for q ticks. Segments of length zero are skipped.
- R4: The order swaps on every strobe. In the swapped order A and B trade places, and each keeps its own segment length.
- R5: The zero time is t0 = PERIOD_TICKS − t1 − t2. The values q, a and b are floor(t0/4), floor(t1/2) and floor(t2/2). The centre zero segment c takes all remaining ticks, so c = PERIOD_TICKS − 2q − 2a − 2b.
- R6: If t1 exceeds the period, t1 is clamped to PERIOD_TICKS and t2 is set to 0. Otherwise, if t1 + t2 exceeds the period, t2 is cut to PERIOD_TICKS − t1. As a result t0 is never negative.
- R7: A transistor whose request drops to 0 is switched off at the next clock edge.
- R8: A transistor switches on at an edge only if its request was 1 in each of the DEAD_TICKS+1 preceding ticks. A request shorter than that produces no pulse at all.
- R9: Dwell times and words are captured only at a strobe. Changes at other times have no effect on the output.
- R10: A strobe that arrives during a period abandons the rest of that period and starts a new one from tick 0 with the newly captured values.
- R11: After a period ends, and while no strobe arrives, the request holds the captured zero-vector word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rstN | input | 1 | Active-low synchronous reset |
| periodStrobe | input | 1 | Starts a period and captures the inputs |
| dwellA | input | TW (6) | Active dwell time t1 in ticks, used with gateA |
| dwellB | input | TW (6) | Active dwell time t2 in ticks, used with gateB |
| gateZero | input | GATE_W (12) | Transistor word for the zero vector |
| gateA | input | GATE_W (12) | Transistor word for the first active vector |
| gateB | input | GATE_W (12) | Transistor word for the second active vector |
| gateOut | output | GATE_W (12) | Gate drive word after the turn-on delay |

## Verification
The bench builds the block with its defaults: a 50-tick period, a 2-tick dead time and 12 transistors. These values make the 6-bit dwell inputs able to reach 63. Both saturation branches can therefore be driven from legal input values. With a 2-tick dead time, a half segment of a single tick is shorter than the turn-on delay, which exercises the case where a pulse is swallowed. Quarter lengths of odd zero times, odd active times whose remainder moves to the centre, and back-to-back periods of alternating order all fall within a few hundred cycles.

// File: rtl/svm_seq_pkg.sv
package svm_seq_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic latchNow;   // capture inputs this edge
    logic running;    // a period is being played out
    logic swapOrder;  // current period uses the swapped order
  } seqCtl_t;

  localparam int SEG_COUNT = 7;

endpackage

// File: rtl/svm_seq_ctrl.sv
module svm_seq_ctrl
  import svm_seq_pkg::*;
#(
  parameter int PERIOD_TICKS = 50,
  localparam int TW = $clog2(PERIOD_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          periodStrobe,
  output seqCtl_t       ctl,
  output logic [TW-1:0] tick
);

  localparam logic [TW-1:0] LAST_TICK = TW'(PERIOD_TICKS - 1);

  logic running;
  logic swapReg;
  logic swapNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      tick     <= '0;
      swapReg  <= 1'b0;
      swapNext <= 1'b0;
    end else if (periodStrobe) begin
      running  <= 1'b1;
      tick     <= '0;
      swapReg  <= swapNext;
      swapNext <= ~swapNext;
    end else if (running) begin
      if (tick == LAST_TICK) begin
        running <= 1'b0;
      end else begin
        tick <= tick + TW'(1);
      end
    end
  end

  always_comb begin
    ctl.latchNow  = periodStrobe;
    ctl.running   = running;
    ctl.swapOrder = swapReg;
  end

endmodule

// File: rtl/svm_seq_path.sv
module svm_seq_path
  import svm_seq_pkg::*;
#(
  parameter int PERIOD_TICKS = 50,
  parameter int GATE_W = 12,
  localparam int TW = $clog2(PERIOD_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [TW-1:0]     tick,
  input  logic [TW-1:0]     dwellA,
  input  logic [TW-1:0]     dwellB,
  input  logic [GATE_W-1:0] gateZero,
  input  logic [GATE_W-1:0] gateA,
  input  logic [GATE_W-1:0] gateB,
  output logic [GATE_W-1:0] targetWord
);

  localparam int SW = TW + 2;
  localparam logic [SW-1:0] PW = SW'(PERIOD_TICKS);

  // Saturation and length split on the raw inputs
  logic [SW-1:0] aExt, bExt, satA, satB, zeroT, quarterT, halfA, halfB, centreT;

  always_comb begin
    aExt = SW'(dwellA);
    bExt = SW'(dwellB);
    if (aExt > PW) begin
      satA = PW;
      satB = '0;
    end else if (aExt + bExt > PW) begin
      satA = aExt;
      satB = PW - aExt;
    end else begin
      satA = aExt;
      satB = bExt;
    end
    zeroT    = PW - satA - satB;
    quarterT = zeroT >> 2;
    halfA    = satA >> 1;
    halfB    = satB >> 1;
    centreT  = PW - (quarterT << 1) - (halfA << 1) - (halfB << 1);
  end

  // Captured period parameters
  logic [TW-1:0]     qReg, hAReg, hBReg, cReg;
  logic [GATE_W-1:0] zWord, aWord, bWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qReg  <= '0;
      hAReg <= '0;
      hBReg <= '0;
      cReg  <= '0;
      zWord <= '0;
      aWord <= '0;
      bWord <= '0;
    end else if (ctl.latchNow) begin
      qReg  <= TW'(quarterT);
      hAReg <= TW'(halfA);
      hBReg <= TW'(halfB);
      cReg  <= TW'(centreT);
      zWord <= gateZero;
      aWord <= gateA;
      bWord <= gateB;
    end
  end

  // Segment table for the current order
  logic [SW-1:0]     segLen [SEG_COUNT];
  logic [GATE_W-1:0] segWord[SEG_COUNT];
  logic [SW-1:0]     segEnd [SEG_COUNT];
  logic [SW-1:0]     firstLen, secondLen;
  logic [GATE_W-1:0] firstWord, secondWord;

  always_comb begin
    firstLen   = ctl.swapOrder ? SW'(hBReg) : SW'(hAReg);
    secondLen  = ctl.swapOrder ? SW'(hAReg) : SW'(hBReg);
    firstWord  = ctl.swapOrder ? bWord : aWord;
    secondWord = ctl.swapOrder ? aWord : bWord;
    segLen[0] = SW'(qReg);  segWord[0] = zWord;
    segLen[1] = firstLen;   segWord[1] = firstWord;
    segLen[2] = secondLen;  segWord[2] = secondWord;
    segLen[3] = SW'(cReg);  segWord[3] = zWord;
    segLen[4] = secondLen;  segWord[4] = secondWord;
    segLen[5] = firstLen;   segWord[5] = firstWord;
    segLen[6] = SW'(qReg);  segWord[6] = zWord;
  end

  generate
    for (genvar s = 0; s < SEG_COUNT; s++) begin : g_end
      if (s == 0) begin : g_first
        assign segEnd[s] = segLen[s];
      end else begin : g_rest
        assign segEnd[s] = segEnd[s-1] + segLen[s];
      end
    end
  endgenerate

  // First segment whose end lies beyond the tick wins
  always_comb begin
    targetWord = zWord;
    if (ctl.running) begin
      for (int k = SEG_COUNT - 1; k >= 0; k--) begin
        if (SW'(tick) < segEnd[k]) targetWord = segWord[k];
      end
    end
  end

endmodule

// File: rtl/svm_dead_gate.sv
module svm_dead_gate #(
  parameter int GATE_W = 12,
  parameter int DEAD_TICKS = 2,
  localparam int DW = (DEAD_TICKS < 1) ? 1 : $clog2(DEAD_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [GATE_W-1:0] targetWord,
  output logic [GATE_W-1:0] gateOut
);

  localparam logic [DW-1:0] WAIT_INIT = DW'(DEAD_TICKS);

  generate
    for (genvar i = 0; i < GATE_W; i++) begin : g_bit
      logic [DW-1:0] waitCnt;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          waitCnt    <= WAIT_INIT;
          gateOut[i] <= 1'b0;
        end else if (!targetWord[i]) begin
          waitCnt    <= WAIT_INIT;
          gateOut[i] <= 1'b0;
        end else if (waitCnt != '0) begin
          waitCnt    <= waitCnt - DW'(1);
          gateOut[i] <= 1'b0;
        end else begin
          gateOut[i] <= 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/svm_segment_seq.sv
module svm_segment_seq
  import svm_seq_pkg::*;
#(
  parameter int PERIOD_TICKS = 50,
  parameter int DEAD_TICKS = 2,
  parameter int GATE_W = 12,
  localparam int TW = $clog2(PERIOD_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              periodStrobe,
  input  logic [TW-1:0]     dwellA,
  input  logic [TW-1:0]     dwellB,
  input  logic [GATE_W-1:0] gateZero,
  input  logic [GATE_W-1:0] gateA,
  input  logic [GATE_W-1:0] gateB,
  output logic [GATE_W-1:0] gateOut
);

  seqCtl_t           ctl;
  logic [TW-1:0]     tick;
  logic [GATE_W-1:0] targetWord;

  svm_seq_ctrl #(.PERIOD_TICKS(PERIOD_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .periodStrobe(periodStrobe),
    .ctl(ctl), .tick(tick)
  );

  svm_seq_path #(.PERIOD_TICKS(PERIOD_TICKS), .GATE_W(GATE_W)) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .tick(tick),
    .dwellA(dwellA), .dwellB(dwellB),
    .gateZero(gateZero), .gateA(gateA), .gateB(gateB),
    .targetWord(targetWord)
  );

  svm_dead_gate #(.GATE_W(GATE_W), .DEAD_TICKS(DEAD_TICKS)) u_dead (
    .clk(clk), .rstN(rstN), .targetWord(targetWord), .gateOut(gateOut)
  );

endmodule

// File: rtl/svm_segment_seq_chk.sv
module svm_segment_seq_chk #(
  parameter int PERIOD_TICKS = 50,
  parameter int DEAD_TICKS = 2,
  parameter int GATE_W = 12,
  localparam int TW = $clog2(PERIOD_TICKS + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              periodStrobe,
  input logic [GATE_W-1:0] gateOut,
  input logic [GATE_W-1:0] targetWord,
  input logic              running,
  input logic [TW-1:0]     tick
);

  localparam int RW = $clog2(DEAD_TICKS + 2);
  localparam logic [RW-1:0] RUN_MAX = RW'(DEAD_TICKS + 1);
  localparam logic [TW-1:0] LAST_TICK = TW'(PERIOD_TICKS - 1);

  generate
    for (genvar i = 0; i < GATE_W; i++) begin : g_bit
      logic [RW-1:0] runLen;
      always_ff @(posedge clk) begin
        if (!rstN) runLen <= '0;
        else if (!targetWord[i]) runLen <= '0;
        else if (runLen != RUN_MAX) runLen <= runLen + RW'(1);
      end

      // R8
      rise_after_dead_chk: assert property (@(posedge clk) disable iff (!rstN)
        $rose(gateOut[i]) |-> runLen == RUN_MAX);

      // R7
      fall_now_chk: assert property (@(posedge clk) disable iff (!rstN)
        !targetWord[i] |=> !gateOut[i]);
    end
  endgenerate

  // R10
  strobe_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodStrobe |=> running && tick == '0);

  // R2
  period_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    running && !periodStrobe && tick == LAST_TICK |=> !running);

  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    running && !periodStrobe && tick != LAST_TICK |=> running && tick == $past(tick) + TW'(1));

endmodule

bind svm_segment_seq svm_segment_seq_chk #(
  .PERIOD_TICKS(PERIOD_TICKS), .DEAD_TICKS(DEAD_TICKS), .GATE_W(GATE_W)
) seqChk (
  .clk(clk), .rstN(rstN), .periodStrobe(periodStrobe), .gateOut(gateOut),
  .targetWord(targetWord), .running(ctl.running), .tick(tick)
);

// File: tb/svm_segment_seq_test.sv
module svm_segment_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int P = 50;
  localparam int DEAD = 2;
  localparam int GW = 12;
  localparam int TW = $clog2(P + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          periodStrobe = 1'b0;
  logic [TW-1:0] dwellA = '0;
  logic [TW-1:0] dwellB = '0;
  logic [GW-1:0] gateZero = '0;
  logic [GW-1:0] gateA = '0;
  logic [GW-1:0] gateB = '0;
  logic [GW-1:0] gateOut;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  // Bench model of the request schedule and turn-on history
  logic [GW-1:0] hist1 = '0, hist2 = '0, hist3 = '0;
  bit            mRun = 0;
  int            mTick = 0;
  bit            mNext = 0;
  int            mLen [7];
  logic [GW-1:0] mWord[7];
  logic [GW-1:0] mZ = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  svm_segment_seq uut (
    .clk(clk), .rstN(rstN), .periodStrobe(periodStrobe),
    .dwellA(dwellA), .dwellB(dwellB),
    .gateZero(gateZero), .gateA(gateA), .gateB(gateB),
    .gateOut(gateOut)
  );

  function automatic logic [GW-1:0] modelTarget();
    int acc = 0;
    if (!mRun) return mZ;
    for (int k = 0; k < 7; k++) begin
      acc += mLen[k];
      if (mTick < acc) return mWord[k];
    end
    return mZ;
  endfunction

  task automatic modelLatch();
    int a = int'(dwellA);
    int b = int'(dwellB);
    int s1, s2, t0, q, fh, sh;
    logic [GW-1:0] fw, sw;
    if (a > P) begin s1 = P; s2 = 0; end
    else if (a + b > P) begin s1 = a; s2 = P - a; end
    else begin s1 = a; s2 = b; end
    t0 = P - s1 - s2;
    q = t0 / 4;
    if (!mNext) begin fw = gateA; fh = s1 / 2; sw = gateB; sh = s2 / 2; end
    else        begin fw = gateB; fh = s2 / 2; sw = gateA; sh = s1 / 2; end
    mLen[0] = q;  mLen[1] = fh; mLen[2] = sh; mLen[3] = P - 2*q - 2*fh - 2*sh;
    mLen[4] = sh; mLen[5] = fh; mLen[6] = q;
    mWord[0] = gateZero; mWord[1] = fw; mWord[2] = sw; mWord[3] = gateZero;
    mWord[4] = sw; mWord[5] = fw; mWord[6] = gateZero;
    mZ = gateZero;
    mNext = !mNext;
    mRun = 1;
    mTick = 0;
  endtask

  task automatic step(input bit stb);
    logic [GW-1:0] expOut;
    @(negedge clk);
    expOut = hist1 & hist2 & hist3;
    checks++;
    if (gateOut !== expOut) begin
      errors++;
      $display("FAIL %s gateOut actual %h expected %h at %0t", curReq, gateOut, expOut, $time);
    end
    hist3 = hist2; hist2 = hist1; hist1 = modelTarget();
    periodStrobe = stb;
    if (stb) modelLatch();
    else if (mRun) begin
      if (mTick == P - 1) mRun = 0;
      else mTick++;
    end
  endtask

  task automatic runTicks(input int n);
    for (int i = 0; i < n; i++) step(1'b0);
  endtask

  task automatic startPeriod(input int t1, input int t2,
                             input logic [GW-1:0] z, input logic [GW-1:0] x,
                             input logic [GW-1:0] y);
    dwellA = TW'(t1); dwellB = TW'(t2);
    gateZero = z; gateA = x; gateB = y;
    step(1'b1);
  endtask

  task automatic testReset();
    curReq = "R1";
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checks++;
      if (gateOut !== '0) begin
        errors++;
        $display("FAIL R1 reset gateOut actual %h expected 000", gateOut);
      end
    end
    rstN = 1'b1;
  endtask

  task automatic testNormalOrder();
    curReq = "R1 R2 R3";
    startPeriod(10, 14, 12'b1100_1100_1100, 12'b0110_0110_0110, 12'b0011_0011_0011);
    runTicks(P + 3);
  endtask

  task automatic testAlternate();
    curReq = "R4";
    startPeriod(10, 14, 12'b1100_1100_1100, 12'b0110_0110_0110, 12'b0011_0011_0011);
    runTicks(P + 3);
    startPeriod(6, 20, 12'hF00, 12'h0F0, 12'h00F);
    runTicks(P + 3);
  endtask

  task automatic testOddSplit();
    curReq = "R5";
    startPeriod(11, 7, 12'hA50, 12'h5A0, 12'h0A5);
    runTicks(P + 2);
    startPeriod(9, 13, 12'h111, 12'h222, 12'h444);
    runTicks(P + 2);
  endtask

  task automatic testSaturate();
    curReq = "R6";
    startPeriod(40, 30, 12'h003, 12'h300, 12'h030);
    runTicks(P + 2);
    startPeriod(60, 5, 12'h0C0, 12'hC00, 12'h00C);
    runTicks(P + 2);
  endtask

  task automatic testDeadTime();
    curReq = "R7 R8";
    startPeriod(3, 4, 12'b1111_0000_1100, 12'b0111_1000_1010, 12'b1000_1111_0001);
    runTicks(P + 4);
    startPeriod(20, 16, 12'hFFF, 12'h000, 12'hF0F);
    runTicks(P + 4);
  endtask

  task automatic testIgnore();
    curReq = "R9";
    startPeriod(20, 20, 12'h821, 12'h142, 12'h284);
    runTicks(10);
    dwellA = TW'(2); dwellB = TW'(3);
    gateZero = 12'hFFF; gateA = 12'h000; gateB = 12'hAAA;
    runTicks(P + 3);
  endtask

  task automatic testRestart();
    curReq = "R10";
    startPeriod(16, 16, 12'h099, 12'h909, 12'h990);
    runTicks(20);
    startPeriod(8, 30, 12'h606, 12'h066, 12'h660);
    runTicks(P + 2);
  endtask

  task automatic testIdle();
    curReq = "R11";
    startPeriod(12, 12, 12'h5A5, 12'hA5A, 12'h3C3);
    runTicks(P + 12);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testNormalOrder();
    testAlternate();
    testOddSplit();
    testSaturate();
    testDeadTime();
    testIgnore();
    testRestart();
    testIdle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule